// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a 32-pin general-purpose I/O bank controlled through a plain register port: a write strobe, a byte address and a data word for writes, with readback that follows the address in the same cycle. Software uses it to drive pins, to read the pins back, and to be told when a pin changes or sits at a chosen level. The bank has one interrupt line that is shared by all pins.

Each register fills a 16-byte slot. Address bits [3:2] pick the access type: a plain write, an OR-in (set) alias, or an AND-NOT (clear) alias. With these aliases, software can change single bits without a read-modify-write sequence. Each pin has its own interrupt logic. The pin is synchronized first. An edge or level detector then raises an event, and a capture enable decides whether that event latches a sticky status bit. A separate interrupt enable decides whether the status bit reaches the shared line. Software can catch both edges of a pin by flipping that pin's polarity bit after each event.

The port carries control and status only. No stream passes through the block, so none of its pins use a valid/ready handshake.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, `pin_oe` is all zero (all pins are inputs) and `irq` is low.
- R2: Register slots, selected by addr[7:4]: 0 output data, 1 pin input (read-only, writes ignored), 2 output enable, 3 capture enable, 4 interrupt enable, 5 level select, 6 polarity, 7 status. `rdata` returns the slot that `addr` selects, in the same cycle.
- R3: Bits addr[3:2] select the write action: 00 replaces the register, 01 ORs `wdata` in, 10 clears the bits that are 1 in `wdata`, and 11 leaves the register unchanged.
- R4: `pin_out` equals the output-data register and `pin_oe` equals the output-enable register, where 1 means the pin is driven.
- R5: Slot 1 returns `pin_in` after a two-flop synchronizer. A change shows up two clock edges after it is sampled, and this holds for pins configured as outputs as well.
- R6: The trigger is set by the level-select bit L and the polarity bit P of each pin. L=0,P=0 gives a falling edge, L=0,P=1 a rising edge, L=1,P=0 a low level, and L=1,P=1 a high level.
- R7: An edge on `pin_in` sets the pin's status bit on the third rising clock edge after the change. The bit is still clear after the second edge.
- R8: Status bits are sticky. Writing 1s through the clear alias of slot 7 (address 0x78) clears them.
- R9: An event sets a status bit only when that pin's capture-enable bit is 1.
- R10: `irq` is the OR over all pins of (status AND interrupt enable). A set status bit whose interrupt enable is 0 does not raise `irq`.
- R11: A polarity change on a pin in edge mode applies to the next transition, so flipping the polarity after each event catches both edges.
- R12: In level mode the status bit is set again on every cycle that the active level lasts, so a clear while the level is still present does not stick.
- R13: If a write that clears a status bit and a new event for that bit happen in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 8 | Register slot [7:4] and write action [3:2] |
| wdata | input | 32 | Write data or bit mask |
| rdata | output | 32 | Readback of the slot selected by `addr` |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output data for the pads |
| pin_oe | output | 32 | Per-pin output enable for the pads |
| irq | output | 1 | Shared bank interrupt |

## Verification
The hardest case to reach is an event landing in the same clock cycle as a software clear of that status bit. The bench first presets the status bit through the set alias. It then drives a rising edge and places the clear write exactly three edges after the pin change, where the synchronizer delay puts the detected event. Catching both edges is also exercised: the polarity bit is flipped after a captured rising edge, and the following falling edge must set the bit again. Level mode is tested by clearing a status bit while its level is still asserted.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_SET   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_NONE  = 2'b11
  } reg_op_e;

  typedef enum int {
    IDX_DOUT   = 0,
    IDX_DIN    = 1,
    IDX_OE     = 2,
    IDX_CAPEN  = 3,
    IDX_IEN    = 4,
    IDX_LEVSEL = 5,
    IDX_POL    = 6,
    IDX_STAT   = 7
  } reg_idx_e;

  localparam int NUM_SLOTS = 8;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  reg_op_e      op,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (hit) begin
      unique case (op)
        OP_WRITE: nxt = wdata;
        OP_SET:   nxt = q | wdata;
        OP_CLEAR: nxt = q & ~wdata;
        default:  nxt = q;
      endcase
    end
    // hardware set beats any software change in the same cycle
    nxt = nxt | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_s,
  input  logic [W-1:0] lev,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] cap_en,
  output logic [W-1:0] events
);
  logic [W-1:0] in_d;
  logic [W-1:0] raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_d <= '0;
    else        in_d <= in_s;
  end

  for (genvar gp = 0; gp < W; gp++) begin : g_pin
    always_comb begin
      unique case ({lev[gp], pol[gp]})
        2'b00:   raw[gp] = in_d[gp] & ~in_s[gp];  // falling edge
        2'b01:   raw[gp] = ~in_d[gp] & in_s[gp];  // rising edge
        2'b10:   raw[gp] = ~in_s[gp];             // low level
        default: raw[gp] = in_s[gp];              // high level
      endcase
    end
  end

  assign events = raw & cap_en;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 4;
  localparam int SEL_W = $clog2(NUM_SLOTS);

  logic [IDX_W-1:0] sel_idx;
  reg_op_e          sel_op;
  logic [NPINS-1:0] reg_q [NUM_SLOTS];
  logic [NPINS-1:0] din_s;
  logic [NPINS-1:0] events;
  logic [NPINS-1:0] stat_q, ien_q, capen_q;

  assign sel_idx = addr[ADDR_W-1:4];
  assign sel_op  = reg_op_e'(addr[3:2]);

  gpio_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (din_s)
  );

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
    if (gi == int'(IDX_DIN)) begin : g_ro
      assign reg_q[gi] = din_s;
    end else begin : g_rw
      logic             hit;
      logic [NPINS-1:0] hw_set;
      assign hit    = wr_en && (sel_idx == IDX_W'(gi)) && (sel_op != OP_NONE);
      assign hw_set = (gi == int'(IDX_STAT)) ? events : '0;
      gpio_alias_reg #(.W(NPINS)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .op     (sel_op),
        .wdata  (wdata),
        .hw_set (hw_set),
        .q      (reg_q[gi])
      );
    end
  end

  assign stat_q  = reg_q[IDX_STAT];
  assign ien_q   = reg_q[IDX_IEN];
  assign capen_q = reg_q[IDX_CAPEN];

  gpio_irq_detect #(.W(NPINS)) u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_s   (din_s),
    .lev    (reg_q[IDX_LEVSEL]),
    .pol    (reg_q[IDX_POL]),
    .cap_en (capen_q),
    .events (events)
  );

  always_comb begin
    rdata = '0;
    if (sel_idx < IDX_W'(NUM_SLOTS)) rdata = reg_q[sel_idx[SEL_W-1:0]];
  end

  assign pin_out = reg_q[IDX_DOUT];
  assign pin_oe  = reg_q[IDX_OE];
  assign irq     = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NPINS-1:0]  wdata,
  input logic [NPINS-1:0]  rdata,
  input logic [NPINS-1:0]  pin_in,
  input logic [NPINS-1:0]  pin_out,
  input logic              irq,
  input logic [NPINS-1:0]  status,
  input logic [NPINS-1:0]  cap_en,
  input logic [NPINS-1:0]  ien
);
  logic [1:0] since_rst;
  logic       stat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign stat_wr = wr_en && (addr[ADDR_W-1:4] == (ADDR_W-4)'(7));

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status & $past(status)) == $past(status))); // R8

  AST_CAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status & ~$past(status) & ~$past(cap_en)) == '0)); // R9

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != '0)); // R10

  AST_DIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && addr[ADDR_W-1:4] == (ADDR_W-4)'(1))
      |-> (rdata == $past(pin_in, 2))); // R5

  AST_OUT_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[ADDR_W-1:2] == (ADDR_W-2)'(1))
      |=> ((pin_out & $past(wdata)) == $past(wdata))); // R3
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .pin_in  (pin_in),
  .pin_out (pin_out),
  .irq     (irq),
  .status  (stat_q),
  .cap_en  (capen_q),
  .ien     (ien_q)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {write addr, write data, read addr, expected readback}
  localparam int NVEC = 11;
  localparam logic [79:0] VEC [NVEC] = '{
    {8'h00, 32'hA5A5_0000, 8'h00, 32'hA5A5_0000},  // R2 R3 plain write
    {8'h04, 32'h0000_00FF, 8'h00, 32'hA5A5_00FF},  // R3 set alias
    {8'h08, 32'hA000_0000, 8'h00, 32'h05A5_00FF},  // R3 clear alias
    {8'h0C, 32'hFFFF_FFFF, 8'h00, 32'h05A5_00FF},  // R3 action 11 ignored
    {8'h20, 32'h0000_FFFF, 8'h20, 32'h0000_FFFF},  // R2
    {8'h28, 32'h0000_F000, 8'h20, 32'h0000_0FFF},  // R3
    {8'h10, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000},  // R2 input slot read-only
    {8'h64, 32'h1234_5678, 8'h60, 32'h1234_5678},  // R2 R3
    {8'h60, 32'h0000_0000, 8'h60, 32'h0000_0000},  // R2
    {8'h54, 32'h0000_000F, 8'h50, 32'h0000_000F},  // R2 R3
    {8'h50, 32'h0000_0000, 8'h50, 32'h0000_0000}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);

    // R1 reset state
    for (int s = 0; s < 8; s++) begin
      if (s == 1) continue;
      peek(8'(s << 4), rv);
      check("R1 reset register", rv, 32'h0);
    end
    check("R1 reset oe", pin_oe, 32'h0);
    check("R1 reset irq", {31'h0, irq}, 32'h0);

    // table walk: R2 R3
    for (int k = 0; k < NVEC; k++) begin
      wr(VEC[k][79:72], VEC[k][71:40]);
      peek(VEC[k][39:32], rv);
      check("R2/R3 table", rv, VEC[k][31:0]);
    end
    check("R4 pin_out", pin_out, 32'h05A5_00FF);
    check("R4 pin_oe", pin_oe, 32'h0000_0FFF);

    // R5 input synchronizer latency, including output pins
    @(negedge clk);
    pin_in = 32'h0000_0A00;
    wait_neg(1);
    peek(8'h10, rv);
    check("R5 after one edge", rv, 32'h0);
    wait_neg(1);
    peek(8'h10, rv);
    check("R5 after two edges", rv, 32'h0000_0A00);
    wr(8'h20, 32'h0);
    @(negedge clk);
    pin_in = 32'h0;
    wait_neg(3);

    // R6 R7 rising edge pin 3
    wr(8'h64, 32'h8);
    wr(8'h34, 32'h8);
    wr(8'h44, 32'h8);
    @(negedge clk);
    pin_in[3] = 1'b1;
    wait_neg(2);
    peek(8'h70, rv);
    check("R7 not before third edge", rv, 32'h0);
    wait_neg(1);
    peek(8'h70, rv);
    check("R7 rising captured", rv, 32'h8);
    check("R10 irq raised", {31'h0, irq}, 32'h1);
    wr(8'h78, 32'h8);
    peek(8'h70, rv);
    check("R8 clear alias", rv, 32'h0);
    check("R8 irq drops", {31'h0, irq}, 32'h0);

    // R11 flip polarity to catch the falling edge
    wr(8'h68, 32'h8);
    @(negedge clk);
    pin_in[3] = 1'b0;
    wait_neg(3);
    peek(8'h70, rv);
    check("R11 falling after flip", rv, 32'h8);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h48, 32'hFFFF_FFFF);

    // R6 falling edge pin 5, R10 enable gating
    @(negedge clk);
    pin_in[5] = 1'b1;
    wait_neg(3);
    wr(8'h34, 32'h20);
    @(negedge clk);
    pin_in[5] = 1'b0;
    wait_neg(3);
    peek(8'h70, rv);
    check("R6 falling captured", rv, 32'h20);
    check("R10 no irq without enable", {31'h0, irq}, 32'h0);
    wr(8'h44, 32'h20);
    check("R10 irq with enable", {31'h0, irq}, 32'h1);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h48, 32'hFFFF_FFFF);

    // R9 capture disabled pin 7
    wr(8'h64, 32'h80);
    @(negedge clk);
    pin_in[7] = 1'b1;
    wait_neg(4);
    peek(8'h70, rv);
    check("R9 no capture when disabled", rv, 32'h0);

    // R12 high level pin 9
    wr(8'h54, 32'h200);
    wr(8'h64, 32'h200);
    wr(8'h34, 32'h200);
    @(negedge clk);
    pin_in[9] = 1'b1;
    wait_neg(3);
    peek(8'h70, rv);
    check("R6 high level captured", rv, 32'h200);
    wr(8'h78, 32'h200);
    peek(8'h70, rv);
    check("R12 clear under level does not stick", rv, 32'h200);
    @(negedge clk);
    pin_in[9] = 1'b0;
    wait_neg(3);
    wr(8'h78, 32'h200);
    peek(8'h70, rv);
    check("R12 clear after level gone", rv, 32'h0);

    // R6 low level pin 11 (pin already low)
    wr(8'h54, 32'h800);
    wr(8'h34, 32'h800);
    wait_neg(1);
    peek(8'h70, rv);
    check("R6 low level captured", rv, 32'h800);
    wr(8'h38, 32'h800);
    wr(8'h58, 32'h800);
    wr(8'h78, 32'hFFFF_FFFF);

    // R13 clear and event in the same cycle, pin 3 rising
    wr(8'h64, 32'h8);
    wr(8'h74, 32'h8);
    @(negedge clk);
    pin_in[3] = 1'b1;
    wait_neg(1);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h78; wdata = 32'h8;
    @(negedge clk);
    wr_en = 1'b0;
    peek(8'h70, rv);
    check("R13 event wins over clear", rv, 32'h8);
    wr(8'h78, 32'h8);
    peek(8'h70, rv);
    check("R8 later clear succeeds", rv, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule